// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns an integer held in a 64-bit register into an IEEE 754 value. The integer may be signed or unsigned, 32 or 64 bits wide. The caller picks one of two result precisions. In double mode the result is a binary64 value. In single mode the value is rounded to binary32 precision and then re-expressed in binary64 layout, so it can sit in a 64-bit floating-point register.

Each conversion is started by a one-cycle valid strobe. The result appears one clock later, together with four status values: a result-class code, a flag that rounding increased the magnitude, an inexact flag, and a sticky inexact summary. A flags-update enable tells the surrounding status logic whether this conversion was allowed to touch the status bits. A 32-bit integer converted to double is always exact, so that one case leaves every status output unchanged.

Top module: `int2fp_unit`

## Requirements
- R1: The type code `in_itype` selects the integer type: 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit, 3 = unsigned 64-bit. For the two 32-bit types only operand bits 31:0 are used; bits 63:32 have no effect on any output.
- R2: A conversion accepted with `in_valid` high at a clock edge is presented on the outputs after that same edge, with `out_valid` high for exactly that one cycle. `out_valid` is low in every cycle that does not follow an accepted conversion.
- R3: For type 0 or 1 with `in_single` low, `out_flags_en` is low. `out_class`, `out_fr`, `out_inexact` and `out_sticky` keep the values they had before the conversion. For every other combination of type and precision, `out_flags_en` is high and all four status outputs are updated.
- R4: Results that cannot be represented exactly are rounded as `in_rmode` selects: 00 = to nearest with ties to even, 01 = toward zero, 10 = toward +infinity, 11 = toward -infinity.
- R5: With `in_single` high, the value is rounded to a 24-bit significand. The output has bit 63 as the sign, bits 62:52 as the binary64 exponent, and bits 51:29 as the binary32 fraction. Bits 28:0 are zero.
- R6: `out_fr` is 1 when rounding increased the magnitude. `out_inexact` is 1 when nonzero bits were discarded. Both flags are 0 for exact results.
- R7: `out_sticky` is set by any updating conversion whose `out_inexact` is 1. Once set, it stays set until reset.
- R8: The class code is 5'b00010 for a zero result, which is always +0 (all 64 bits zero). It is 5'b00100 for a positive result and 5'b01000 for a negative result.
- R9: The most negative signed 32-bit and 64-bit values convert exactly to -2^31 and -2^63.
- R10: When rounding carries out of an all-ones significand, the result is the next power of two. Its fraction is zero and its exponent is one higher.
- R11: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Starts a conversion this cycle |
| in_operand | input | 64 | Integer source register |
| in_itype | input | 2 | Integer type code |
| in_single | input | 1 | 1 = round to binary32 precision |
| in_rmode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result presented this cycle |
| out_result | output | 64 | Floating-point bit pattern in binary64 layout |
| out_class | output | 5 | Result-class code |
| out_fr | output | 1 | Rounding increased the magnitude |
| out_inexact | output | 1 | Bits were discarded |
| out_sticky | output | 1 | Sticky inexact summary |
| out_flags_en | output | 1 | Status outputs were updated by this conversion |

## Verification
The bench builds the block with its default 64-bit register width. That width is the only one at which the two significand widths and the most negative signed 64-bit value line up with the integer types. Directed cases put values exactly on halfway points and one unit above them, in both precisions. This exercises every rounding direction, the ties-to-even choice, and carry-out from an all-ones significand. Random operands over all type codes, precisions and modes then compare each cycle against a model that rounds by remainder arithmetic rather than guard and sticky bits.

// File: rtl/int2fp_pkg.sv
package int2fp_pkg;
  localparam int XLEN     = 64;
  localparam int LZW      = $clog2(XLEN) + 1;
  localparam int D_FRAC   = 52;
  localparam int S_FRAC   = 23;
  localparam int D_EXPW   = 11;
  localparam int D_BIAS   = 1023;
  localparam int CLSW     = 5;

  localparam logic [CLSW-1:0] CLS_ZERO = 5'b00010;
  localparam logic [CLSW-1:0] CLS_POS  = 5'b00100;
  localparam logic [CLSW-1:0] CLS_NEG  = 5'b01000;

  typedef enum logic [1:0] {
    RM_NEAR  = 2'b00,
    RM_ZERO  = 2'b01,
    RM_PINF  = 2'b10,
    RM_NINF  = 2'b11
  } rmode_e;

  // number of zero bits above the most significant one
  function automatic logic [LZW-1:0] lead_zeros(input logic [XLEN-1:0] v);
    logic [LZW-1:0] n;
    logic           hit;
    n   = '0;
    hit = 1'b0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (!hit) begin
        if (v[i]) hit = 1'b1;
        else      n   = n + 1'b1;
      end
    end
    return n;
  endfunction

  // increment decision from the kept lsb, guard, sticky and sign
  function automatic logic round_up(input rmode_e rm, input logic neg,
                                    input logic lsb, input logic g,
                                    input logic s);
    case (rm)
      RM_NEAR: return g & (s | lsb);
      RM_ZERO: return 1'b0;
      RM_PINF: return (g | s) & ~neg;
      default: return (g | s) & neg;
    endcase
  endfunction
endpackage

// File: rtl/int2fp_magnitude.sv
module int2fp_magnitude
  import int2fp_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] operand,
  input  logic [1:0]   itype,
  output logic         neg,
  output logic [W-1:0] mag
);
  localparam int HALF = W / 2;

  logic         is_signed;
  logic         narrow;
  logic [W-1:0] widened;

  always_comb begin
    is_signed = ~itype[0];
    narrow    = ~itype[1];
    if (narrow)
      widened = is_signed ? {{HALF{operand[HALF-1]}}, operand[HALF-1:0]}
                          : {{HALF{1'b0}}, operand[HALF-1:0]};
    else
      widened = operand;
    neg = is_signed & widened[W-1];
    // unsigned wrap makes the most negative value come out as 2^(W-1)
    mag = neg ? (~widened + 1'b1) : widened;
  end
endmodule

// File: rtl/int2fp_normalize.sv
module int2fp_normalize
  import int2fp_pkg::*;
#(
  parameter int W = XLEN,
  parameter int Z = LZW
) (
  input  logic [W-1:0] mag,
  output logic [W-1:0] norm,
  output logic [Z-1:0] lz
);
  always_comb begin
    lz   = lead_zeros(mag);
    norm = mag << lz;
  end
endmodule

// File: rtl/int2fp_round_pack.sv
module int2fp_round_pack
  import int2fp_pkg::*;
#(
  parameter int W = XLEN,
  parameter int Z = LZW
) (
  input  logic [W-1:0]    norm,
  input  logic [Z-1:0]    lz,
  input  logic            neg,
  input  logic            single,
  input  logic [1:0]      rmode,
  output logic [63:0]     result,
  output logic [CLSW-1:0] cls,
  output logic            incr,
  output logic            inexact
);
  localparam int DLO = W - 1 - D_FRAC;
  localparam int SLO = W - 1 - S_FRAC;
  localparam int PAD = D_FRAC - S_FRAC;
  localparam logic [D_EXPW-1:0] EXP_TOP = D_EXPW'(D_BIAS + W - 1);

  logic              zero;
  logic              g_d, s_d, g_s, s_s;
  logic              inc_d, inc_s;
  logic [D_FRAC:0]   sum_d;
  logic [S_FRAC:0]   sum_s;
  logic              carry;
  logic [D_FRAC-1:0] frac;
  logic [D_EXPW-1:0] expo;

  always_comb begin
    zero  = ~norm[W-1];
    g_d   = norm[DLO-1];
    s_d   = |norm[DLO-2:0];
    g_s   = norm[SLO-1];
    s_s   = |norm[SLO-2:0];
    inc_d = round_up(rmode_e'(rmode), neg, norm[DLO], g_d, s_d);
    inc_s = round_up(rmode_e'(rmode), neg, norm[SLO], g_s, s_s);
    sum_d = {1'b0, norm[W-2:DLO]} + {{D_FRAC{1'b0}}, inc_d};
    sum_s = {1'b0, norm[W-2:SLO]} + {{S_FRAC{1'b0}}, inc_s};
    if (single) begin
      carry   = sum_s[S_FRAC];
      frac    = {sum_s[S_FRAC-1:0], {PAD{1'b0}}};
      incr    = inc_s;
      inexact = g_s | s_s;
    end else begin
      carry   = sum_d[D_FRAC];
      frac    = sum_d[D_FRAC-1:0];
      incr    = inc_d;
      inexact = g_d | s_d;
    end
    expo = EXP_TOP - D_EXPW'(lz) + D_EXPW'(carry);
    if (zero) begin
      result = '0;
      cls    = CLS_ZERO;
    end else begin
      result = {neg, expo, frac};
      cls    = neg ? CLS_NEG : CLS_POS;
    end
  end
endmodule

// File: rtl/int2fp_unit.sv
module int2fp_unit
  import int2fp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [63:0] in_operand,
  input  logic [1:0]  in_itype,
  input  logic        in_single,
  input  logic [1:0]  in_rmode,
  output logic        out_valid,
  output logic [63:0] out_result,
  output logic [4:0]  out_class,
  output logic        out_fr,
  output logic        out_inexact,
  output logic        out_sticky,
  output logic        out_flags_en
);
  logic            neg;
  logic [XLEN-1:0] mag;
  logic [XLEN-1:0] norm;
  logic [LZW-1:0]  lz;
  logic [63:0]     res_c;
  logic [CLSW-1:0] cls_c;
  logic            incr_c, inexact_c;
  logic            upd_c;

  int2fp_magnitude #(.W(XLEN)) u_mag (
    .operand(in_operand), .itype(in_itype), .neg(neg), .mag(mag));

  int2fp_normalize #(.W(XLEN), .Z(LZW)) u_norm (
    .mag(mag), .norm(norm), .lz(lz));

  int2fp_round_pack #(.W(XLEN), .Z(LZW)) u_rnd (
    .norm(norm), .lz(lz), .neg(neg), .single(in_single), .rmode(in_rmode),
    .result(res_c), .cls(cls_c), .incr(incr_c), .inexact(inexact_c));

  // 32-bit source into double never rounds: status stays as it was
  assign upd_c = in_itype[1] | in_single;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_class    <= '0;
      out_fr       <= 1'b0;
      out_inexact  <= 1'b0;
      out_sticky   <= 1'b0;
      out_flags_en <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      out_flags_en <= in_valid & upd_c;
      if (in_valid) begin
        out_result <= res_c;
        if (upd_c) begin
          out_class   <= cls_c;
          out_fr      <= incr_c;
          out_inexact <= inexact_c;
          out_sticky  <= out_sticky | inexact_c;
        end
      end
    end
  end
endmodule

module int2fp_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_operand,
  input logic [1:0]  in_itype,
  input logic        in_single,
  input logic        out_valid,
  input logic [63:0] out_result,
  input logic [4:0]  out_class,
  input logic        out_fr,
  input logic        out_inexact,
  input logic        out_sticky,
  input logic        out_flags_en
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_exact_no_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_itype[1] && !in_single) |=> !out_flags_en);
  assert_status_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_flags_en) |-> ($stable(out_class) && $stable(out_fr)
      && $stable(out_inexact) && $stable(out_sticky)));
  assert_single_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_single) |=> (out_result[28:0] == 29'd0));
  assert_fr_needs_inexact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_fr |-> out_inexact);
  assert_sticky_covers_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_inexact |-> out_sticky);
  assert_sticky_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(out_sticky));
  assert_class_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_class));
  assert_zero_is_plus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_operand == 64'd0) |=> (out_result == 64'd0));
endmodule

bind int2fp_unit int2fp_unit_chk chk_i (.*);

// File: tb/int2fp_unit_test.sv
`timescale 1ns/1ps
module int2fp_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_operand = '0;
  logic [1:0]  in_itype = '0;
  logic        in_single = 1'b0;
  logic [1:0]  in_rmode = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic [4:0]  out_class;
  logic        out_fr, out_inexact, out_sticky, out_flags_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string cur_req = "R11";

  always #10 clk = ~clk;

  int2fp_unit uut (.*);

  // behavioural reference: remainder-based rounding on plain integers
  task automatic ref_conv(input logic [63:0] op, input logic [1:0] it,
                          input logic sgl, input logic [1:0] rm,
                          output logic [63:0] res, output logic [4:0] cls,
                          output logic fr, output logic fi);
    longint signed sv;
    logic [63:0] mag, kept, rem, half, mask;
    bit neg, inc;
    int pos, p, sh;
    case (it)
      2'd0: sv = longint'($signed(op[31:0]));
      2'd1: sv = longint'({32'd0, op[31:0]});
      default: sv = longint'(op);
    endcase
    neg = (it[0] == 1'b0) && (sv < 0);
    mag = neg ? 64'(-sv) : 64'(sv);
    fr = 0; fi = 0;
    if (mag == 0) begin
      res = '0; cls = 5'b00010; return;
    end
    pos = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) pos = i;
    p = sgl ? 24 : 53;
    sh = pos - (p - 1);
    rem = 0; half = 0;
    if (sh <= 0) kept = mag << (-sh);
    else begin
      mask = (64'd1 << sh) - 1;
      kept = mag >> sh;
      rem  = mag & mask;
      half = 64'd1 << (sh - 1);
    end
    case (rm)
      2'b00: inc = (rem > half) || (rem == half && rem != 0 && kept[0]);
      2'b01: inc = 0;
      2'b10: inc = (rem != 0) && !neg;
      default: inc = (rem != 0) && neg;
    endcase
    kept = kept + 64'(inc);
    if (kept == (64'd1 << p)) begin kept = kept >> 1; pos = pos + 1; end
    res = {neg, 11'(pos + 1023),
           52'((kept & ((64'd1 << (p - 1)) - 1)) << (53 - p))};
    cls = neg ? 5'b01000 : 5'b00100;
    fr = inc; fi = (rem != 0);
  endtask

  logic        m_valid = 0, m_fr = 0, m_fi = 0, m_sticky = 0, m_upd = 0;
  logic [63:0] m_res = 0;
  logic [4:0]  m_cls = 0;
  string       m_req = "R11";

  always @(posedge clk) begin
    logic [63:0] r; logic [4:0] c; logic f, x;
    if (!rst_n) begin
      m_valid = 0; m_res = 0; m_cls = 0; m_fr = 0; m_fi = 0;
      m_sticky = 0; m_upd = 0; m_req = "R11";
    end else begin
      m_valid = in_valid;
      m_upd = in_valid && (in_itype[1] || in_single);
      if (in_valid) begin
        ref_conv(in_operand, in_itype, in_single, in_rmode, r, c, f, x);
        m_res = r; m_req = cur_req;
        if (m_upd) begin
          m_cls = c; m_fr = f; m_fi = x; m_sticky = m_sticky | x;
        end
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R2", "valid", 64'(out_valid), 64'(m_valid));
      chk(m_req, "result", out_result, m_res);
      chk("R8", "class", 64'(out_class), 64'(m_cls));
      chk("R6", "fr", 64'(out_fr), 64'(m_fr));
      chk("R6", "inexact", 64'(out_inexact), 64'(m_fi));
      chk("R7", "sticky", 64'(out_sticky), 64'(m_sticky));
      chk("R3", "flags_en", 64'(out_flags_en), 64'(m_upd));
    end
  end

  task automatic op(input string req, input logic [63:0] v, input logic [1:0] it,
                    input logic sgl, input logic [1:0] rm);
    @(negedge clk);
    cur_req = req; in_operand = v; in_itype = it; in_single = sgl;
    in_rmode = rm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // direct check of a literal expected value one cycle after issue
  task automatic op_exp(input string req, input logic [63:0] v, input logic [1:0] it,
                        input logic sgl, input logic [1:0] rm, input logic [63:0] exp);
    op(req, v, it, sgl, rm);
    chk(req, "literal", out_result, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "reset result", out_result, 64'd0);
    chk("R11", "reset sticky", 64'(out_sticky), 64'd0);
    rst_n = 1'b1;
    // R1: low 32 bits only
    op_exp("R1", 64'hDEAD_BEEF_FFFF_FFFB, 2'd0, 0, 2'b00, 64'hC014_0000_0000_0000);
    op_exp("R1", 64'hDEAD_BEEF_0000_0007, 2'd1, 0, 2'b00, 64'h401C_0000_0000_0000);
    // R8 zero and signs
    op_exp("R8", 64'd0, 2'd2, 0, 2'b00, 64'd0);
    op_exp("R8", 64'd1, 2'd3, 1, 2'b00, 64'h3FF0_0000_0000_0000);
    // R10: carry from all-ones significand
    op_exp("R10", 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 0, 2'b00, 64'h43F0_0000_0000_0000);
    op_exp("R10", 64'h0000_0000_FFFF_FFFF, 2'd1, 1, 2'b00, 64'h41F0_0000_0000_0000);
    // R3: exact path keeps the set status from above
    op("R3", 64'h0000_0000_1234_5678, 2'd0, 0, 2'b10);
    chk("R3", "fr held", 64'(out_fr), 64'd1);
    chk("R3", "flags_en low", 64'(out_flags_en), 64'd0);
    // R4: tie 2^53+1 in all modes, odd tie 2^53+3
    op_exp("R4", 64'h0020_0000_0000_0001, 2'd3, 0, 2'b00, 64'h4340_0000_0000_0000);
    op_exp("R4", 64'h0020_0000_0000_0001, 2'd3, 0, 2'b01, 64'h4340_0000_0000_0000);
    op_exp("R4", 64'h0020_0000_0000_0001, 2'd3, 0, 2'b10, 64'h4340_0000_0000_0001);
    op_exp("R4", 64'h0020_0000_0000_0001, 2'd3, 0, 2'b11, 64'h4340_0000_0000_0000);
    op_exp("R4", 64'hFFDF_FFFF_FFFF_FFFF, 2'd2, 0, 2'b11, 64'hC340_0000_0000_0001);
    op_exp("R4", 64'h0020_0000_0000_0003, 2'd3, 0, 2'b00, 64'h4340_0000_0000_0002);
    // R5: single precision rounding
    op_exp("R5", 64'h0000_0000_0100_0001, 2'd1, 1, 2'b00, 64'h4170_0000_0000_0000);
    op_exp("R5", 64'h0000_0000_0100_0003, 2'd0, 1, 2'b00, 64'h4170_0000_4000_0000);
    op_exp("R5", 64'h0000_0000_0100_0001, 2'd1, 1, 2'b10, 64'h4170_0000_2000_0000);
    // R9: most negative values
    op_exp("R9", 64'h8000_0000_0000_0000, 2'd2, 0, 2'b00, 64'hC3E0_0000_0000_0000);
    op_exp("R9", 64'h0000_0000_8000_0000, 2'd0, 0, 2'b00, 64'hC1E0_0000_0000_0000);
    op_exp("R9", 64'h8000_0000_0000_0000, 2'd2, 1, 2'b01, 64'hC3E0_0000_0000_0000);
    // R7: exact updating op keeps sticky high
    op("R7", 64'd4, 2'd2, 0, 2'b00);
    chk("R7", "sticky kept", 64'(out_sticky), 64'd1);
    // random sweep, compared by the per-cycle model
    for (int k = 0; k < 400; k++) begin
      logic [63:0] v;
      v = {$urandom, $urandom} >> ($urandom_range(0, 63));
      op("R4", v, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
         2'($urandom_range(0, 3)));
    end
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule